// File: doc/BRIEF.md
# Three-Slot Receive Message FIFO

This block buffers up to three received frames that have already passed acceptance filtering in a CAN-style controller. The receive path offers each frame with a one-cycle store strobe. If a slot is free, the frame is written in. If all three slots are taken, the frame is dropped and a sticky overrun flag is raised.

Software always sees the oldest stored frame on the mailbox output. It frees that slot by writing 1 to a release bit in the status register. The release bit stays set for one cycle. Hardware then performs the pop and clears the bit.

The status register shows the pending count, a sticky full flag and the overrun flag. Software clears the full and overrun flags by writing 1 to them. A second register holds three interrupt enables. A single interrupt line is raised by any enabled condition.

Top module: `rx_mbox_fifo`

## Requirements
- R1: After reset, the status register (offset 0x10) and the enable register (offset 0x14) read 0, `irq_o` is 0 and `mbox_frame_o` is 0.
- R2: Each accepted store raises the pending count (status bits 1:0) by one. Frames leave in arrival order. `mbox_frame_o` shows the oldest pending frame, and shows 0 while the count is 0.
- R3: Writing a 1 to status bit 5 makes bit 5 read 1 in the next cycle. On the edge after that, hardware clears bit 5, lowers the count by one and moves the mailbox to the next frame.
- R4: A release while the count is 0 leaves the count and the mailbox unchanged. Bit 5 still clears after one cycle.
- R5: The full flag (status bit 3) is set when a store brings the count to 3. It stays set after releases and after writes of 0 to it.
- R6: A store while the count is 3 and no release is being processed sets the overrun flag (status bit 4). The frame is discarded, the count stays 3 and the mailbox is unchanged.
- R7: A store on the same edge as a release with the count at 3 is accepted. The count stays 3, the oldest frame is dropped, and overrun is not set.
- R8: The enable register uses bit 0 for pending, bit 1 for full and bit 2 for overrun. These bits read back as written, and all other bits read 0. Status bit 2 and bits 31:6 read 0.
- R9: `irq_o` is the OR of three terms: bit 0 with count nonzero, bit 1 with full, and bit 2 with overrun.
- R10: Writing 1 to status bit 4 or bit 3 clears overrun or full, and leaves the other flag as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| rx_store_i | input | 1 | One-cycle strobe offering a filtered frame |
| rx_frame_i | input | FRAME_W | Frame offered with the strobe |
| bus_addr_i | input | ADDR_W | Register address for reads and writes |
| bus_we_i | input | 1 | Register write strobe |
| bus_wdata_i | input | DATA_W | Register write data |
| bus_rdata_o | output | DATA_W | Register read data for `bus_addr_i` (combinational) |
| mbox_frame_o | output | FRAME_W | Oldest pending frame, or 0 when the FIFO is empty |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong read or write pointer shows up as the wrong frame on `mbox_frame_o`. This is visible in the cycle after the release that exposes it. The bench compares every frame it drains against a queue of expected frames, so ordering faults are caught. A count that drifts shows up in status bits 1:0 one edge after the store or release that caused it. If the release bit does not clear, or pops twice, this also shows there. Faults in the flag or enable logic show up on status bits 3 and 4 and on `irq_o` in the cycle after the triggering edge. The bench checks these right at the overrun edge and at the full-with-release edge.

// File: rtl/rx_mbox_fifo.sv
module rx_mbox_fifo #(
  parameter int FRAME_W  = 64,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int STAT_OFS = 16,
  parameter int IE_OFS   = 20
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rx_store_i,
  input  logic [FRAME_W-1:0] rx_frame_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic               bus_we_i,
  input  logic [DATA_W-1:0]  bus_wdata_i,
  output logic [DATA_W-1:0]  bus_rdata_o,
  output logic [FRAME_W-1:0] mbox_frame_o,
  output logic               irq_o
);
  localparam int SLOTS = 3;
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);
  localparam logic [ADDR_W-1:0] IE_A   = ADDR_W'(IE_OFS);
  localparam int REL_B  = 5;
  localparam int OVR_B  = 4;
  localparam int FULL_B = 3;

  logic [FRAME_W-1:0] slot_q [SLOTS];
  logic [1:0] rd_q, wr_q, cnt_q, cnt_d;
  logic       rel_q, full_q, ovr_q;
  logic [2:0] ie_q;
  logic       wr_stat, wr_ie, pop, accept, drop;
  logic       unused_wbits;

  function automatic logic [1:0] step(input logic [1:0] p);
    return (p == 2'(SLOTS - 1)) ? 2'd0 : p + 2'd1;
  endfunction

  assign wr_stat = bus_we_i && (bus_addr_i == STAT_A);
  assign wr_ie   = bus_we_i && (bus_addr_i == IE_A);
  assign pop     = rel_q && (cnt_q != 2'd0);
  assign accept  = rx_store_i && ((cnt_q != 2'(SLOTS)) || pop);
  assign drop    = rx_store_i && !accept;
  assign unused_wbits = ^bus_wdata_i[DATA_W-1:6];

  always_comb begin
    case ({accept, pop})
      2'b10:   cnt_d = cnt_q + 2'd1;
      2'b01:   cnt_d = cnt_q - 2'd1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      rd_q   <= '0;
      wr_q   <= '0;
      cnt_q  <= '0;
      rel_q  <= 1'b0;
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
      ie_q   <= '0;
    end else begin
      cnt_q  <= cnt_d;
      rel_q  <= wr_stat && bus_wdata_i[REL_B];
      full_q <= (accept && cnt_d == 2'(SLOTS)) ||
                (full_q && !(wr_stat && bus_wdata_i[FULL_B]));
      ovr_q  <= drop || (ovr_q && !(wr_stat && bus_wdata_i[OVR_B]));
      if (pop)    rd_q <= step(rd_q);
      if (accept) wr_q <= step(wr_q);
      if (wr_ie)  ie_q <= bus_wdata_i[2:0];
    end
  end

  always_ff @(posedge clk_i) begin
    if (accept) slot_q[wr_q] <= rx_frame_i;
  end

  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i == STAT_A) begin
      bus_rdata_o[REL_B]  = rel_q;
      bus_rdata_o[OVR_B]  = ovr_q;
      bus_rdata_o[FULL_B] = full_q;
      bus_rdata_o[1:0]    = cnt_q;
    end else if (bus_addr_i == IE_A) begin
      bus_rdata_o[2:0] = ie_q;
    end
  end

  assign mbox_frame_o = (cnt_q != 2'd0) ? slot_q[rd_q] : '0;
  assign irq_o = (ie_q[0] && cnt_q != 2'd0) || (ie_q[1] && full_q) || (ie_q[2] && ovr_q);
endmodule

// File: rtl/rx_mbox_fifo_chk.sv
module rx_mbox_fifo_chk #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int STAT_OFS = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rx_store_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic              bus_we_i,
  input logic [DATA_W-1:0] bus_wdata_i,
  input logic [1:0]        cnt_q,
  input logic              rel_q,
  input logic              full_q,
  input logic              ovr_q,
  input logic [2:0]        ie_q,
  input logic              irq_o
);
  logic wst;
  assign wst = bus_we_i && (bus_addr_i == ADDR_W'(STAT_OFS));

  assert_count_up_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_store_i && !rel_q && cnt_q != 2'd3 |=> cnt_q == $past(cnt_q) + 2'd1);
  assert_rel_clears_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel_q && !(wst && bus_wdata_i[5]) |=> !rel_q);
  assert_pop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel_q && cnt_q != 2'd0 && !rx_store_i |=> cnt_q == $past(cnt_q) - 2'd1);
  assert_empty_release_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel_q && cnt_q == 2'd0 && !rx_store_i |=> cnt_q == 2'd0);
  assert_full_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_store_i && !rel_q && cnt_q == 2'd2 |=> full_q);
  assert_overrun_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_store_i && !rel_q && cnt_q == 2'd3 |=> ovr_q && cnt_q == 2'd3);
  assert_swap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_store_i && rel_q && cnt_q == 2'd3 && !ovr_q |=> !ovr_q && cnt_q == 2'd3);
  assert_irq_ovr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_q && ie_q[2] |-> irq_o);
  assert_irq_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ie_q == 3'd0 |-> !irq_o);
  assert_full_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wst && bus_wdata_i[3] && !rx_store_i |=> !full_q);
endmodule

bind rx_mbox_fifo rx_mbox_fifo_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAT_OFS(STAT_OFS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rx_store_i(rx_store_i), .bus_addr_i(bus_addr_i),
  .bus_we_i(bus_we_i), .bus_wdata_i(bus_wdata_i), .cnt_q(cnt_q), .rel_q(rel_q),
  .full_q(full_q), .ovr_q(ovr_q), .ie_q(ie_q), .irq_o(irq_o)
);

// File: tb/rx_mbox_fifo_tb_top.sv
module rx_mbox_fifo_tb_top;
  localparam int FW = 64;
  localparam logic [7:0] STAT = 8'h10;
  localparam logic [7:0] IEA  = 8'h14;

  logic clk = 0, rst_n = 0;
  logic store = 0;
  logic [FW-1:0] frame = '0;
  logic [7:0] addr = '0;
  logic we = 0;
  logic [31:0] wdata = '0, rdata;
  logic [FW-1:0] mbox;
  logic irq;

  int n_run = 0, n_fail = 0;
  logic [FW-1:0] exp_q[$];
  int m_cnt = 0;
  bit m_full = 0, m_ovr = 0;
  logic [2:0] m_ie = 0;

  always #2.5 clk = ~clk;

  rx_mbox_fifo dut_i (
    .clk_i(clk), .rst_ni(rst_n), .rx_store_i(store), .rx_frame_i(frame),
    .bus_addr_i(addr), .bus_we_i(we), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .mbox_frame_o(mbox), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [FW-1:0] act, input logic [FW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    addr = a; #1; v = rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1;
    @(negedge clk); we = 0; wdata = '0;
  endtask

  function automatic logic [31:0] m_stat();
    return {26'd0, 1'b0, m_ovr, m_full, 1'b0, 2'(m_cnt)};
  endfunction

  function automatic logic m_irq();
    return (m_ie[0] && m_cnt != 0) || (m_ie[1] && m_full) || (m_ie[2] && m_ovr);
  endfunction

  task automatic push(input logic [FW-1:0] f);
    @(negedge clk); store = 1; frame = f;
    @(negedge clk); store = 0;
    if (m_cnt < 3) begin
      exp_q.push_back(f); m_cnt++;
      if (m_cnt == 3) m_full = 1;
    end else m_ovr = 1;
  endtask

  task automatic monitor_head(input string req);
    chk(req, mbox, (exp_q.size() != 0) ? exp_q[0] : '0);
  endtask

  task automatic release_check(input string req);
    logic [31:0] s;
    monitor_head(req);
    wr(STAT, 32'h20);
    rd(STAT, s); chk("R3 release bit set", FW'(s[5]), FW'(1));
    @(negedge clk);
    if (m_cnt != 0) begin void'(exp_q.pop_front()); m_cnt--; end
    rd(STAT, s); chk({req, " status after release"}, FW'(s), FW'(m_stat()));
    monitor_head(req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] s;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(STAT, s); chk("R1 status reset", FW'(s), 0);
    rd(IEA, s);  chk("R1 enable reset", FW'(s), 0);
    chk("R1 irq reset", FW'(irq), 0);
    chk("R1 mailbox reset", mbox, 0);

    wr(IEA, 32'h7); rd(IEA, s); chk("R8 enable readback", FW'(s), 7);
    wr(IEA, 32'hFFFF_FFFA); rd(IEA, s); chk("R8 upper bits zero", FW'(s), 2);
    wr(IEA, 0); m_ie = 0;

    release_check("R4 empty release");

    push(64'hA1A1_0000_0000_0001);
    rd(STAT, s); chk("R2 count one", FW'(s), FW'(m_stat()));
    monitor_head("R2 head first");
    chk("R9 irq masked", FW'(irq), FW'(m_irq()));
    wr(IEA, 1); m_ie = 1; #1;
    chk("R9 irq pending", FW'(irq), FW'(m_irq()));

    push(64'hB2B2_0000_0000_0002);
    push(64'hC3C3_0000_0000_0003);
    rd(STAT, s); chk("R5 full set", FW'(s), FW'(m_stat()));
    wr(STAT, 0); rd(STAT, s); chk("R5 full holds on write 0", FW'(s), FW'(m_stat()));

    push(64'hD4D4_0000_0000_0004);
    rd(STAT, s); chk("R6 overrun set", FW'(s), FW'(m_stat()));
    monitor_head("R6 head unchanged");

    release_check("R3 pop");
    rd(STAT, s); chk("R5 full sticky after release", FW'(s[3]), 1);

    wr(STAT, 32'h08); m_full = 0;
    rd(STAT, s); chk("R10 full cleared, overrun kept", FW'(s), FW'(m_stat()));
    wr(IEA, 4); m_ie = 4; #1;
    chk("R9 irq overrun", FW'(irq), FW'(m_irq()));
    wr(STAT, 32'h10); m_ovr = 0; #1;
    rd(STAT, s); chk("R10 overrun cleared", FW'(s), FW'(m_stat()));
    chk("R9 irq drops", FW'(irq), FW'(m_irq()));
    wr(IEA, 2); m_ie = 2;

    push(64'hE5E5_0000_0000_0005);
    rd(STAT, s); chk("R5 full again", FW'(s), FW'(m_stat()));
    wr(STAT, 32'h08); m_full = 0;

    // R7: release and store on the same edge with three pending
    @(negedge clk); addr = STAT; wdata = 32'h20; we = 1;
    @(negedge clk); we = 0; wdata = '0; store = 1; frame = 64'hF6F6_0000_0000_0006;
    @(negedge clk); store = 0;
    void'(exp_q.pop_front()); exp_q.push_back(64'hF6F6_0000_0000_0006); m_full = 1;
    rd(STAT, s); chk("R7 swap no overrun", FW'(s), FW'(m_stat()));
    monitor_head("R7 head advanced");
    chk("R9 irq full", FW'(irq), FW'(m_irq()));

    release_check("R2 drain order");
    release_check("R2 drain order");
    release_check("R2 drain order");
    release_check("R4 empty release again");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule